// File: doc/BRIEF.md
# Dual Stack Pointer Address Generator

This unit keeps two 8-bit stack pointers for a processor whose data memory is 4 bits wide. It turns stack operations into a sequence of memory addresses, write data and write enables, one nibble per clock. The first stack, the address stack, stores 16-bit program addresses. Each entry takes four nibbles at the addresses pointer×4 to pointer×4+3. The second stack, the register stack, stores single nibbles at the address the pointer gives.

A one-cycle command strobe starts each operation. The operations are: push of a return address, push of a register nibble, pop of a register nibble, return, software interrupt, and a load of either pointer from an 8-bit value. For a return the unit puts the restored program counter on its output. For a software interrupt it puts out the vector address. The block also drives an interrupt-enable gate. This gate stays off until software has loaded both pointers. It also stays off while a pointer load waits for its partner load.

Top module: `dstk_agen`

## Requirements
- R1: While reset is high and in the first cycle after it, both pointers read 00h, irq_enable is 0, and busy, done, mem_we, pc_valid and reg_valid are 0.
- R2: op_code 1 (address push) decrements the address-stack pointer at acceptance. The next four cycles write nibble k of save_pc (bits 4k+3:4k) to address pointer×4+k, for k = 0, 1, 2, 3 in that order.
- R3: Both pointers are 8 bits and wrap: decrementing 00h gives FFh and incrementing FFh gives 00h. Address-stack addresses are therefore 0000h to 03FFh.
- R4: op_code 2 (register push) decrements the register-stack pointer at acceptance. In the next cycle it writes save_reg to the address equal to the new pointer, with done high.
- R5: op_code 3 (register pop) reads the address equal to the register-stack pointer for one cycle. In that cycle reg_valid and done are high and reg_out carries the read nibble. The pointer then increments.
- R6: op_code 4 (return) reads addresses pointer×4+k for k = 0 to 3. In the fourth cycle pc_valid and done are high, and pc_out carries the four nibbles with the lowest address as bits 3:0. The address-stack pointer then increments.
- R7: op_code 5 (software interrupt) decrements both pointers at acceptance. It writes save_reg to the register stack in the first cycle, then writes save_pc as in R2. In the final cycle pc_valid is high with pc_out = 0100h + swi_vec.
- R8: irq_enable stays 0 until both pointers have been loaded: op_code 6 loads the address-stack pointer from ba_in, and op_code 7 loads the register-stack pointer from ba_in.
- R9: After a load of one pointer, irq_enable stays 0 until the other pointer is loaded.
- R10: A command offered while busy is high has no effect on pointers, memory traffic or outputs.
- R11: busy is high exactly during the cycles of an operation's sequence. mem_we is high only in its write cycles, and done marks the last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Command strobe |
| op_code | input | 3 | Command: 1 push addr, 2 push reg, 3 pop reg, 4 return, 5 soft interrupt, 6 load SP-addr, 7 load SP-reg |
| save_pc | input | 16 | Return address to save |
| save_reg | input | 4 | Register or flag nibble to save |
| swi_vec | input | 6 | Software interrupt vector offset |
| ba_in | input | 8 | Pointer load value |
| mem_rdata | input | 4 | Data memory read nibble (same cycle) |
| mem_addr | output | 16 | Data memory address |
| mem_wdata | output | 4 | Data memory write nibble |
| mem_we | output | 1 | Data memory write enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of a sequence |
| pc_valid | output | 1 | pc_out is valid |
| pc_out | output | 16 | Restored PC or interrupt vector |
| reg_valid | output | 1 | reg_out is valid |
| reg_out | output | 4 | Popped register nibble |
| sp1_out | output | 8 | Address-stack pointer |
| sp2_out | output | 8 | Register-stack pointer |
| irq_enable | output | 1 | Interrupt acceptance gate |

## Verification
The bound assertions check these rules on every cycle: writes occur only while busy, a started sequence runs to its done cycle, busy falls only after done, pc_valid appears only on a done cycle, pops never write, and irq_enable rises only after an accepted pointer load. The bench's reference model is needed to show the values themselves. These are the nibble order and addresses of each sequence, pointer wrap at 00h and FFh, the assembled return address, the vector value, the pairing rule for pointer loads, and that commands given while busy are ignored.

// File: rtl/dstk_pkg.sv
package dstk_pkg;
    localparam int PTR_W  = 8;
    localparam int ADDR_W = 16;
    localparam int NIB_W  = 4;
    localparam int PC_W   = 16;
    localparam int VEC_W  = 6;
    localparam int NIBS   = PC_W / NIB_W;
    localparam int CNT_W  = $clog2(NIBS);
    localparam logic [PC_W-1:0] VEC_BASE = 16'h0100;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_PUSH_PC  = 3'd1,
        OP_PUSH_REG = 3'd2,
        OP_POP_REG  = 3'd3,
        OP_RET      = 3'd4,
        OP_SWI      = 3'd5,
        OP_LD_SP1   = 3'd6,
        OP_LD_SP2   = 3'd7
    } dstk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WPC, ST_RPC, ST_WREG, ST_RREG
    } dstk_st_e;

    typedef enum logic [1:0] {
        PTR_HOLD, PTR_DEC, PTR_INC, PTR_LOAD
    } ptr_act_e;

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [PTR_W-1:0] sp,
                                                   input logic [CNT_W-1:0] k);
        return ADDR_W'({sp, k});
    endfunction
endpackage

// File: rtl/dstk_ptr.sv
module dstk_ptr
    import dstk_pkg::*;
#(
    parameter int W = PTR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ptr_act_e     act,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] val,
    output logic         loaded
);
    always_ff @(posedge clk) begin
        if (rst) begin
            val    <= '0;
            loaded <= 1'b0;
        end else begin
            case (act)
                PTR_DEC:  val <= val - 1'b1;
                PTR_INC:  val <= val + 1'b1;
                PTR_LOAD: begin
                    val    <= ld_val;
                    loaded <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dstk_gate.sv
module dstk_gate (
    input  logic clk,
    input  logic rst,
    input  logic ld1,
    input  logic ld2,
    input  logic ok1,
    input  logic ok2,
    output logic irq_en
);
    logic pend1, pend2;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend1 <= 1'b0;
            pend2 <= 1'b0;
        end else if (ld1) begin
            if (pend2) pend2 <= 1'b0;
            else       pend1 <= 1'b1;
        end else if (ld2) begin
            if (pend1) pend1 <= 1'b0;
            else       pend2 <= 1'b1;
        end
    end

    assign irq_en = ok1 & ok2 & ~pend1 & ~pend2;
endmodule

// File: rtl/dstk_seq.sv
module dstk_seq
    import dstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  dstk_op_e          op,
    input  logic [PC_W-1:0]   save_pc,
    input  logic [NIB_W-1:0]  save_reg,
    input  logic [VEC_W-1:0]  vec,
    input  logic [NIB_W-1:0]  mem_rdata,
    input  logic [PTR_W-1:0]  sp1,
    input  logic [PTR_W-1:0]  sp2,
    output ptr_act_e          sp1_act,
    output ptr_act_e          sp2_act,
    output logic              ld1,
    output logic              ld2,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NIB_W-1:0]  mem_wdata,
    output logic              mem_we,
    output logic              busy,
    output logic              done,
    output logic              pc_valid,
    output logic [PC_W-1:0]   pc_out,
    output logic              reg_valid,
    output logic [NIB_W-1:0]  reg_out
);
    dstk_st_e          st;
    logic [CNT_W-1:0]  cnt;
    logic [PC_W-1:0]   pc_buf;
    logic [PC_W-1:0]   rd_acc;
    logic [NIB_W-1:0]  reg_buf;
    logic [VEC_W-1:0]  vec_q;
    logic              is_swi;
    logic              accept;
    logic              last;

    assign accept = op_valid && (st == ST_IDLE);
    assign last   = (cnt == CNT_W'(NIBS - 1));
    assign busy   = (st != ST_IDLE);

    always_comb begin
        sp1_act   = PTR_HOLD;
        sp2_act   = PTR_HOLD;
        ld1       = 1'b0;
        ld2       = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        done      = 1'b0;
        pc_valid  = 1'b0;
        pc_out    = '0;
        reg_valid = 1'b0;
        reg_out   = '0;
        if (accept) begin
            case (op)
                OP_PUSH_PC:  sp1_act = PTR_DEC;
                OP_PUSH_REG: sp2_act = PTR_DEC;
                OP_SWI: begin
                    sp1_act = PTR_DEC;
                    sp2_act = PTR_DEC;
                end
                OP_LD_SP1: begin
                    sp1_act = PTR_LOAD;
                    ld1     = 1'b1;
                end
                OP_LD_SP2: begin
                    sp2_act = PTR_LOAD;
                    ld2     = 1'b1;
                end
                default: ;
            endcase
        end
        case (st)
            ST_WPC: begin
                mem_we    = 1'b1;
                mem_addr  = slot_addr(sp1, cnt);
                mem_wdata = pc_buf[int'(cnt)*NIB_W +: NIB_W];
                done      = last;
                pc_valid  = last && is_swi;
                pc_out    = VEC_BASE | PC_W'(vec_q);
            end
            ST_RPC: begin
                mem_addr = slot_addr(sp1, cnt);
                done     = last;
                pc_valid = last;
                pc_out   = {mem_rdata, rd_acc[PC_W-1:NIB_W]};
                if (last) sp1_act = PTR_INC;
            end
            ST_WREG: begin
                mem_we    = 1'b1;
                mem_addr  = ADDR_W'(sp2);
                mem_wdata = reg_buf;
                done      = !is_swi;
            end
            ST_RREG: begin
                mem_addr  = ADDR_W'(sp2);
                reg_valid = 1'b1;
                reg_out   = mem_rdata;
                done      = 1'b1;
                sp2_act   = PTR_INC;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            pc_buf  <= '0;
            rd_acc  <= '0;
            reg_buf <= '0;
            vec_q   <= '0;
            is_swi  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    cnt    <= '0;
                    is_swi <= (op == OP_SWI);
                    case (op)
                        OP_PUSH_PC: begin
                            pc_buf <= save_pc;
                            st     <= ST_WPC;
                        end
                        OP_PUSH_REG: begin
                            reg_buf <= save_reg;
                            st      <= ST_WREG;
                        end
                        OP_POP_REG: st <= ST_RREG;
                        OP_RET:     st <= ST_RPC;
                        OP_SWI: begin
                            pc_buf  <= save_pc;
                            reg_buf <= save_reg;
                            vec_q   <= vec;
                            st      <= ST_WREG;
                        end
                        default: ;
                    endcase
                end
                ST_WPC: begin
                    cnt <= cnt + 1'b1;
                    if (last) st <= ST_IDLE;
                end
                ST_RPC: begin
                    cnt    <= cnt + 1'b1;
                    rd_acc <= {mem_rdata, rd_acc[PC_W-1:NIB_W]};
                    if (last) st <= ST_IDLE;
                end
                ST_WREG: st <= is_swi ? ST_WPC : ST_IDLE;
                ST_RREG: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dstk_agen.sv
module dstk_agen
    import dstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [PC_W-1:0]   save_pc,
    input  logic [NIB_W-1:0]  save_reg,
    input  logic [VEC_W-1:0]  swi_vec,
    input  logic [PTR_W-1:0]  ba_in,
    input  logic [NIB_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NIB_W-1:0]  mem_wdata,
    output logic              mem_we,
    output logic              busy,
    output logic              done,
    output logic              pc_valid,
    output logic [PC_W-1:0]   pc_out,
    output logic              reg_valid,
    output logic [NIB_W-1:0]  reg_out,
    output logic [PTR_W-1:0]  sp1_out,
    output logic [PTR_W-1:0]  sp2_out,
    output logic              irq_enable
);
    ptr_act_e sp1_act, sp2_act;
    logic     ld1, ld2, ok1, ok2;

    dstk_seq u_seq (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op(dstk_op_e'(op_code)),
        .save_pc(save_pc), .save_reg(save_reg), .vec(swi_vec),
        .mem_rdata(mem_rdata), .sp1(sp1_out), .sp2(sp2_out),
        .sp1_act(sp1_act), .sp2_act(sp2_act), .ld1(ld1), .ld2(ld2),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .busy(busy), .done(done), .pc_valid(pc_valid), .pc_out(pc_out),
        .reg_valid(reg_valid), .reg_out(reg_out)
    );

    dstk_ptr #(.W(PTR_W)) u_sp1 (
        .clk(clk), .rst(rst), .act(sp1_act), .ld_val(ba_in),
        .val(sp1_out), .loaded(ok1)
    );

    dstk_ptr #(.W(PTR_W)) u_sp2 (
        .clk(clk), .rst(rst), .act(sp2_act), .ld_val(ba_in),
        .val(sp2_out), .loaded(ok2)
    );

    dstk_gate u_gate (
        .clk(clk), .rst(rst), .ld1(ld1), .ld2(ld2),
        .ok1(ok1), .ok2(ok2), .irq_en(irq_enable)
    );
endmodule

// File: rtl/dstk_agen_chk.sv
module dstk_agen_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [2:0] op_code,
    input logic       mem_we,
    input logic       busy,
    input logic       done,
    input logic       pc_valid,
    input logic       reg_valid,
    input logic       irq_enable
);
    // R11
    we_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R11
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    // R10
    seq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R6
    pc_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        pc_valid |-> done);

    // R5
    pop_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        reg_valid |-> !mem_we);

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_enable) |-> $past(op_valid && !busy && (op_code == 3'd6 || op_code == 3'd7)));
endmodule

bind dstk_agen dstk_agen_chk u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .mem_we(mem_we), .busy(busy), .done(done), .pc_valid(pc_valid),
    .reg_valid(reg_valid), .irq_enable(irq_enable)
);

// File: tb/dstk_agen_bench.sv
module dstk_agen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [15:0] save_pc = 16'h0;
    logic [3:0]  save_reg = 4'h0;
    logic [5:0]  swi_vec = 6'h0;
    logic [7:0]  ba_in = 8'h0;
    logic [3:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [3:0]  mem_wdata;
    logic        mem_we, busy, done, pc_valid, reg_valid, irq_enable;
    logic [15:0] pc_out;
    logic [3:0]  reg_out;
    logic [7:0]  sp1_out, sp2_out;

    always #5 clk = ~clk;

    dstk_agen u_dstk_agen (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .save_pc(save_pc), .save_reg(save_reg), .swi_vec(swi_vec), .ba_in(ba_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .busy(busy), .done(done), .pc_valid(pc_valid),
        .pc_out(pc_out), .reg_valid(reg_valid), .reg_out(reg_out),
        .sp1_out(sp1_out), .sp2_out(sp2_out), .irq_enable(irq_enable)
    );

    // bench-side data memory driven by the design
    logic [3:0] bmem [0:1023];
    always @(posedge clk) if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
    assign mem_rdata = bmem[mem_addr[9:0]];

    // reference model
    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [3:0]  wd;
        logic        done;
        logic        pcv;
        logic [15:0] pc;
        logic        nv;
        logic [3:0]  nib;
        logic        busy;
        logic [7:0]  s1;
        logic [7:0]  s2;
        logic        irq;
    } exp_t;

    exp_t   q[$];
    int     mmem [0:1023];
    int     m_s1 = 0, m_s2 = 0;
    bit     m_ok1 = 0, m_ok2 = 0, m_p1 = 0, m_p2 = 0;
    int     errors = 0, checks = 0;
    bit     run = 0, finished = 0;
    string  cur_req = "R1";

    function automatic bit m_irq();
        return m_ok1 && m_ok2 && !m_p1 && !m_p2;
    endfunction

    function automatic exp_t blank();
        exp_t e;
        e = '0;
        e.s1 = 8'(m_s1);
        e.s2 = 8'(m_s2);
        e.irq = m_irq();
        return e;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run && !rst) begin
            exp_t e;
            if (q.size() != 0) e = q.pop_front();
            else e = blank();
            chk("busy", int'(busy), int'(e.busy));
            chk("mem_we", int'(mem_we), int'(e.we));
            chk("done", int'(done), int'(e.done));
            chk("pc_valid", int'(pc_valid), int'(e.pcv));
            chk("reg_valid", int'(reg_valid), int'(e.nv));
            chk("sp1", int'(sp1_out), int'(e.s1));
            chk("sp2", int'(sp2_out), int'(e.s2));
            chk("irq_enable", int'(irq_enable), int'(e.irq));
            if (e.busy) chk("mem_addr", int'(mem_addr), int'(e.addr));
            if (e.we)   chk("mem_wdata", int'(mem_wdata), int'(e.wd));
            if (e.pcv)  chk("pc_out", int'(pc_out), int'(e.pc));
            if (e.nv)   chk("reg_out", int'(reg_out), int'(e.nib));
        end
    end

    task automatic wait_idle();
        while (q.size() != 0) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic issue(input logic [2:0] op);
        wait_idle();
        @(negedge clk);
        #1;
        op_valid = 1'b1;
        op_code  = op;
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        op_code  = 3'd0;
    endtask

    task automatic add_pc_writes(input logic [15:0] pc, input bit is_swi, input logic [5:0] v);
        for (int k = 0; k < 4; k++) begin
            exp_t e;
            e = blank();
            e.busy = 1; e.we = 1;
            e.addr = 16'(m_s1 * 4 + k);
            e.wd = pc[4*k +: 4];
            e.done = (k == 3);
            e.pcv = is_swi && (k == 3);
            e.pc = 16'h0100 + 16'(v);
            mmem[m_s1 * 4 + k] = int'(pc[4*k +: 4]);
            q.push_back(e);
        end
    endtask

    task automatic push_pc(input logic [15:0] pc);
        save_pc = pc;
        issue(3'd1);
        m_s1 = (m_s1 + 255) % 256;
        add_pc_writes(pc, 0, 6'h0);
        wait_idle();
    endtask

    task automatic push_reg(input logic [3:0] v);
        exp_t e;
        save_reg = v;
        issue(3'd2);
        m_s2 = (m_s2 + 255) % 256;
        e = blank();
        e.busy = 1; e.we = 1; e.addr = 16'(m_s2); e.wd = v; e.done = 1;
        mmem[m_s2] = int'(v);
        q.push_back(e);
        wait_idle();
    endtask

    task automatic pop_reg();
        exp_t e;
        issue(3'd3);
        e = blank();
        e.busy = 1; e.addr = 16'(m_s2); e.nv = 1; e.nib = 4'(mmem[m_s2]); e.done = 1;
        q.push_back(e);
        m_s2 = (m_s2 + 1) % 256;
        wait_idle();
    endtask

    task automatic do_ret();
        logic [15:0] pc;
        issue(3'd4);
        for (int k = 0; k < 4; k++) pc[4*k +: 4] = 4'(mmem[m_s1 * 4 + k]);
        for (int k = 0; k < 4; k++) begin
            exp_t e;
            e = blank();
            e.busy = 1; e.addr = 16'(m_s1 * 4 + k);
            e.done = (k == 3); e.pcv = (k == 3); e.pc = pc;
            q.push_back(e);
        end
        m_s1 = (m_s1 + 1) % 256;
        wait_idle();
    endtask

    task automatic do_swi(input logic [15:0] pc, input logic [3:0] f, input logic [5:0] v);
        exp_t e;
        save_pc = pc; save_reg = f; swi_vec = v;
        issue(3'd5);
        m_s1 = (m_s1 + 255) % 256;
        m_s2 = (m_s2 + 255) % 256;
        e = blank();
        e.busy = 1; e.we = 1; e.addr = 16'(m_s2); e.wd = f;
        mmem[m_s2] = int'(f);
        q.push_back(e);
        add_pc_writes(pc, 1, v);
        wait_idle();
    endtask

    task automatic load_sp(input bit second, input logic [7:0] v);
        ba_in = v;
        issue(second ? 3'd7 : 3'd6);
        if (!second) begin
            m_s1 = int'(v); m_ok1 = 1;
            if (m_p2) m_p2 = 0; else m_p1 = 1;
        end else begin
            m_s2 = int'(v); m_ok2 = 1;
            if (m_p1) m_p1 = 0; else m_p2 = 1;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=complete");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            bmem[i] = 4'h0;
            mmem[i] = 0;
        end
        // R1 reset state while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        chk("sp1 in reset", int'(sp1_out), 0);
        chk("sp2 in reset", int'(sp2_out), 0);
        chk("irq in reset", int'(irq_enable), 0);
        chk("busy in reset", int'(busy), 0);
        chk("we in reset", int'(mem_we), 0);
        rst = 1'b0;
        run = 1;
        @(negedge clk);
        #2;

        // R8 and R9 pointer load pairing
        cur_req = "R8";
        load_sp(0, 8'h10);
        load_sp(1, 8'h40);
        cur_req = "R9";
        load_sp(0, 8'h20);
        push_reg(4'h3);
        load_sp(1, 8'h40);

        // R2 and R6 address push then return
        cur_req = "R2";
        push_pc(16'hBEEF);
        push_pc(16'h0A5C);
        cur_req = "R6";
        do_ret();
        do_ret();

        // R4 and R5 register stack order
        cur_req = "R4";
        push_reg(4'hA);
        push_reg(4'h5);
        cur_req = "R5";
        pop_reg();
        pop_reg();

        // R3 wrap of both pointers
        cur_req = "R3";
        load_sp(0, 8'h00);
        load_sp(1, 8'h00);
        push_pc(16'h1234);
        do_ret();
        push_reg(4'hC);
        pop_reg();
        load_sp(0, 8'hFF);
        do_ret();
        load_sp(1, 8'hFF);
        pop_reg();

        // R7 software interrupt then unwind
        cur_req = "R7";
        load_sp(0, 8'h30);
        load_sp(1, 8'h80);
        do_swi(16'h4321, 4'h9, 6'h2A);
        do_ret();
        pop_reg();
        do_swi(16'hFEDC, 4'h6, 6'h3F);

        // R10 commands while busy are ignored
        cur_req = "R10";
        save_pc = 16'h7777;
        issue(3'd1);
        m_s1 = (m_s1 + 255) % 256;
        add_pc_writes(16'h7777, 0, 6'h0);
        @(negedge clk);
        #1;
        ba_in = 8'h55; op_valid = 1'b1; op_code = 3'd6;
        @(posedge clk);
        #1;
        op_code = 3'd2; save_reg = 4'hE;
        @(posedge clk);
        #1;
        op_valid = 1'b0; op_code = 3'd0;
        wait_idle();
        cur_req = "R11";
        do_ret();
        wait_idle();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule